// File: doc/BRIEF.md
# SDR SDRAM Refresh Scheduler

This block keeps a four-bank single-data-rate SDRAM refreshed. A free-running interval timer marks each point at which one auto-refresh falls due. A backlog counter holds the refreshes that have fallen due but have not yet been issued. While that counter is non-zero, the block asks the main memory controller for the command bus. The counter saturates at eight, and an urgent flag rises when it is full, so the controller can stop postponing refreshes and give the bus to this block.

When the controller grants the bus, the block drives raw SDRAM command pins itself. If the controller reports any open bank, the block first closes every bank with a precharge-all command (A10 high) and waits out the precharge time. It then issues the auto-refresh command and keeps driving NOP for the rest of the row cycle time. After that it hands the bus back. The precharge and row-cycle waits are derived from nanosecond parameters and the clock period, each rounded up to whole clocks. The timer does not start until the controller signals that SDRAM initialisation is complete.

Top module: `refresh_sched`

## Requirements
- R1: After `init_done` is first sampled high, the first `ref_req` appears exactly INTERVAL_CLKS rising edges later (that edge included). Further refreshes fall due every INTERVAL_CLKS edges after that.
- R2: While `init_done` has never been sampled high since reset, `ref_req` stays low, however long that lasts.
- R3: The backlog of due refreshes saturates at 8. Letting ten or more intervals pass with no grant and then draining yields exactly 8 refreshes, plus any that fall due during the drain.
- R4: `ref_urgent` is high exactly when the backlog holds 8. It falls after the first refresh of a full backlog.
- R5: On a grant while any bit of `bank_open` is set, the command in the cycle after the grant edge is precharge-all: {cs_n,ras_n,cas_n,we_n,a10} = 0,0,1,0,1.
- R6: Auto-refresh is {cs_n,ras_n,cas_n,we_n} = 0,0,0,1 with a10 = 0. It appears TRP_CLKS cycles after the precharge-all, with NOP in between, or in the cycle right after the grant edge when no bank is open. TRP_CLKS = ceil(TRP_PS/CLK_PERIOD_PS).
- R7: For the TRC_CLKS-1 cycles after the auto-refresh, the command is NOP {0,1,1,1} with a10 = 0. TRC_CLKS = ceil(TRC_PS/CLK_PERIOD_PS). `ref_busy` is high from the cycle after the grant edge through the last of those cycles, and low in the cycle after.
- R8: While not busy, the command is deselect {1,1,1,1} with a10 = 0. A grant given while `ref_req` is low is ignored: the block stays idle with deselect.
- R9: Each auto-refresh removes one refresh from the backlog. `ref_req` is low while busy and is high when idle with a non-empty backlog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | SDRAM initialisation complete; starts the interval timer |
| bank_open | input | NUM_BANKS | One bit per bank, high when a row is open |
| ref_gnt | input | 1 | Command bus granted to this block (sampled while `ref_req` is high) |
| ref_req | output | 1 | Refresh wanted: backlog non-empty and block idle |
| ref_urgent | output | 1 | Backlog full (8 pending) |
| ref_busy | output | 1 | Block owns the command bus |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_a10 | output | 1 | Address bit 10, high for precharge of all banks |

## Verification
The refresh sequence is tried with every pattern of open banks, from all closed, through single banks, to all open, each with a random delay between request and grant. This separates the short path (refresh straight away) from the precharge path, and shows whether every bank bit is taken into account. A long pause with no grants fills the backlog past its limit; draining it then tells a saturating counter from one that wraps or overcounts. A grant given without a request, and a long wait before initialisation completes, show that neither one starts a sequence or a request early.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_REF  = 2'd2
    } seq_state_e;

    // Bit order: cs_n, ras_n, cas_n, we_n, a10
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_DESEL = 5'b11110;
    localparam sdr_cmd_t CMD_NOP   = 5'b01110;
    localparam sdr_cmd_t CMD_PREA  = 5'b00101;
    localparam sdr_cmd_t CMD_AREF  = 5'b00010;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/refsched_timer.sv
module refsched_timer #(
    parameter int unsigned INTERVAL_CLKS = 1040
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL_CLKS > 2) ? $clog2(INTERVAL_CLKS) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CLKS - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } timer_t;

    timer_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run)
            r_d.cnt = '0;
        else if (r_q.cnt == LAST)
            r_d.cnt = '0;
        else
            r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick = run && (r_q.cnt == LAST);

endmodule

// File: rtl/refsched_backlog.sv
module refsched_backlog #(
    parameter int unsigned MAX_PENDING = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add,
    input  logic take,
    output logic nonzero,
    output logic full
);
    localparam int unsigned CW = $clog2(MAX_PENDING + 1);
    localparam logic [CW-1:0] TOP = CW'(MAX_PENDING);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } backlog_t;

    backlog_t r_d, r_q;
    logic     inc, dec;

    always_comb begin
        inc = add  && (r_q.cnt != TOP);
        dec = take && (r_q.cnt != '0);
        r_d = r_q;
        case ({inc, dec})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign nonzero = (r_q.cnt != '0);
    assign full    = (r_q.cnt == TOP);

endmodule

// File: rtl/refsched_seq.sv
module refsched_seq
    import refsched_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned TRP_CLKS  = 3,
    parameter int unsigned TRC_CLKS  = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_BANKS-1:0] bank_open,
    output sdr_cmd_t             cmd,
    output logic                 busy,
    output logic                 issued
);
    localparam int unsigned MAXW = (TRP_CLKS > TRC_CLKS) ? TRP_CLKS : TRC_CLKS;
    localparam int unsigned WW   = $clog2(MAXW + 1);
    localparam logic [WW-1:0] RP_LOAD = WW'(TRP_CLKS - 1);
    localparam logic [WW-1:0] RC_LOAD = WW'(TRC_CLKS - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [WW-1:0] wait_cnt;
        sdr_cmd_t      cmd;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cmd = CMD_DESEL;
                if (start) begin
                    if (|bank_open) begin
                        r_d.st       = ST_PRE;
                        r_d.wait_cnt = RP_LOAD;
                        r_d.cmd      = CMD_PREA;
                    end else begin
                        r_d.st       = ST_REF;
                        r_d.wait_cnt = RC_LOAD;
                        r_d.cmd      = CMD_AREF;
                    end
                end
            end
            ST_PRE: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st       = ST_REF;
                    r_d.wait_cnt = RC_LOAD;
                    r_d.cmd      = CMD_AREF;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - 1'b1;
                    r_d.cmd      = CMD_NOP;
                end
            end
            ST_REF: begin
                if (r_q.wait_cnt == '0) begin
                    r_d.st  = ST_IDLE;
                    r_d.cmd = CMD_DESEL;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt - 1'b1;
                    r_d.cmd      = CMD_NOP;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.cmd = CMD_DESEL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.wait_cnt <= '0;
            r_q.cmd      <= CMD_DESEL;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd    = r_q.cmd;
    assign busy   = (r_q.st != ST_IDLE);
    assign issued = (r_q.st == ST_REF) && (r_q.wait_cnt == RC_LOAD);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int unsigned NUM_BANKS     = 4,
    parameter int unsigned INTERVAL_CLKS = 1040,
    parameter int unsigned MAX_PENDING   = 8,
    parameter int unsigned CLK_PERIOD_PS = 7500,
    parameter int unsigned TRP_PS        = 20000,
    parameter int unsigned TRC_PS        = 65000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init_done,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 ref_gnt,
    output logic                 ref_req,
    output logic                 ref_urgent,
    output logic                 ref_busy,
    output logic                 cmd_cs_n,
    output logic                 cmd_ras_n,
    output logic                 cmd_cas_n,
    output logic                 cmd_we_n,
    output logic                 cmd_a10
);
    localparam int unsigned TRP_CLKS = ceil_div(TRP_PS, CLK_PERIOD_PS);
    localparam int unsigned TRC_CLKS = ceil_div(TRC_PS, CLK_PERIOD_PS);

    logic     due_tick, have_pending, issued;
    sdr_cmd_t cmd;

    refsched_timer #(.INTERVAL_CLKS(INTERVAL_CLKS)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (init_done),
        .tick (due_tick)
    );

    refsched_backlog #(.MAX_PENDING(MAX_PENDING)) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .add    (due_tick),
        .take   (issued),
        .nonzero(have_pending),
        .full   (ref_urgent)
    );

    refsched_seq #(
        .NUM_BANKS(NUM_BANKS),
        .TRP_CLKS (TRP_CLKS),
        .TRC_CLKS (TRC_CLKS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ref_req && ref_gnt),
        .bank_open(bank_open),
        .cmd      (cmd),
        .busy     (ref_busy),
        .issued   (issued)
    );

    assign ref_req   = have_pending && !ref_busy;
    assign cmd_cs_n  = cmd.cs_n;
    assign cmd_ras_n = cmd.ras_n;
    assign cmd_cas_n = cmd.cas_n;
    assign cmd_we_n  = cmd.we_n;
    assign cmd_a10   = cmd.a10;

endmodule

// File: rtl/refsched_checker.sv
module refsched_checker #(
    parameter int unsigned TRP_CLKS = 3,
    parameter int unsigned TRC_CLKS = 9
) (
    input logic clk,
    input logic rst_n,
    input logic init_done,
    input logic ref_req,
    input logic ref_urgent,
    input logic ref_busy,
    input logic cmd_cs_n,
    input logic cmd_ras_n,
    input logic cmd_cas_n,
    input logic cmd_we_n,
    input logic cmd_a10
);
    localparam int unsigned SW = $clog2(TRP_CLKS + TRC_CLKS + 1);
    localparam logic [SW-1:0] SAT = SW'(TRP_CLKS + TRC_CLKS);

    logic          is_prea, is_aref, is_nop;
    logic          init_seen_q;
    logic [SW-1:0] since_pre_q, since_ref_q;

    assign is_prea = !cmd_cs_n && !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;
    assign is_aref = !cmd_cs_n && !cmd_ras_n && !cmd_cas_n &&  cmd_we_n;
    assign is_nop  = !cmd_cs_n &&  cmd_ras_n &&  cmd_cas_n &&  cmd_we_n && !cmd_a10;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_seen_q <= 1'b0;
            since_pre_q <= SAT;
            since_ref_q <= SAT;
        end else begin
            if (init_done) init_seen_q <= 1'b1;
            if (is_prea)               since_pre_q <= SW'(1);
            else if (since_pre_q != SAT) since_pre_q <= since_pre_q + 1'b1;
            if (is_aref)               since_ref_q <= SW'(1);
            else if (since_ref_q != SAT) since_ref_q <= since_ref_q + 1'b1;
        end
    end

    AST_NO_REQ_BEFORE_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        !init_seen_q |-> !ref_req) else $error("request before init"); // R2

    AST_URGENT_WANTS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> (ref_req || ref_busy)) else $error("urgent without request"); // R4

    AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |-> (cmd_a10 && ref_busy)) else $error("precharge not all banks"); // R5

    AST_AREF_AFTER_TRP: assert property (@(posedge clk) disable iff (!rst_n)
        is_aref |-> (since_pre_q >= SW'(TRP_CLKS))) else $error("refresh too soon after precharge"); // R6

    AST_HOLDOFF_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ref_q < SW'(TRC_CLKS)) |-> (is_nop && ref_busy)) else $error("hold-off not NOP"); // R7

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_busy |-> (cmd_cs_n && !cmd_a10)) else $error("idle drives command"); // R8

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ref_busy |-> !ref_req) else $error("request while busy"); // R9

endmodule

bind refresh_sched refsched_checker #(
    .TRP_CLKS(TRP_CLKS),
    .TRC_CLKS(TRC_CLKS)
) u_refsched_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_done (init_done),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .ref_busy  (ref_busy),
    .cmd_cs_n  (cmd_cs_n),
    .cmd_ras_n (cmd_ras_n),
    .cmd_cas_n (cmd_cas_n),
    .cmd_we_n  (cmd_we_n),
    .cmd_a10   (cmd_a10)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 4;
    localparam int INTERVAL   = 64;
    localparam int EXP_TRP    = (20000 + 7500 - 1) / 7500;
    localparam int EXP_TRC    = (65000 + 7500 - 1) / 7500;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_done = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          ref_gnt = 1'b0;
    logic          ref_req, ref_urgent, ref_busy;
    logic          cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int m_edges  = 0;
    int m_pend   = 0;
    int m_adds   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(.NUM_BANKS(NB), .INTERVAL_CLKS(INTERVAL)) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .init_done(init_done), .bank_open(bank_open),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
        .ref_busy(ref_busy), .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n),
        .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n), .cmd_a10(cmd_a10)
    );

    function automatic logic [4:0] cmd_now();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10};
    endfunction

    // Expected backlog model, built from R1, R3 and R9
    always @(posedge clk) begin
        bit add, take;
        if (rst_n && init_done) begin
            m_edges = m_edges + 1;
            add  = (m_edges % INTERVAL == 0) && (m_pend != 8);
            take = (cmd_now() == 5'b00010) && (m_pend != 0);
            if (add) m_adds = m_adds + 1;
            m_pend = m_pend + int'(add) - int'(take);
        end
    end

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks = n_checks + 1;
            n_fail   = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks = n_checks + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_cmd(input logic [4:0] exp, input bit exp_busy, input string tag);
        chk(cmd_now() == exp && ref_busy == exp_busy, tag,
            int'({cmd_now(), ref_busy}), int'({exp, exp_busy}));
    endtask

    // Grant once and follow the whole sequence (R5, R6, R7, R8)
    task automatic do_refresh(input logic [NB-1:0] mask);
        bank_open = mask;
        ref_gnt   = 1'b1;
        step();
        ref_gnt   = 1'b0;
        if (mask != '0) begin
            chk_cmd(5'b00101, 1'b1, "R5 precharge-all after grant");
            for (int i = 1; i < EXP_TRP; i++) begin
                step();
                chk_cmd(5'b01110, 1'b1, "R6 NOP during precharge wait");
            end
            step();
        end
        chk_cmd(5'b00010, 1'b1, "R6 auto-refresh");
        chk(ref_req == 1'b0, "R9 no request while busy", int'(ref_req), 0);
        for (int i = 1; i < EXP_TRC; i++) begin
            step();
            chk_cmd(5'b01110, 1'b1, "R7 hold-off NOP");
        end
        step();
        chk_cmd(5'b11110, 1'b0, "R7 bus released");
        bank_open = '0;
    endtask

    task automatic wait_req();
        while (!ref_req) step();
    endtask

    initial begin
        int drained, adds0, pend0;
        void'($urandom(32'd4242));
        repeat (3) step();
        chk_cmd(5'b11110, 1'b0, "R8 reset deselect");
        chk(ref_req == 0 && ref_urgent == 0, "R8 reset flags", int'({ref_req, ref_urgent}), 0);
        rst_n = 1'b1;

        // R2: long wait without init_done
        for (int i = 0; i < 3 * INTERVAL; i++) begin
            step();
            if (ref_req) break;
        end
        chk(ref_req == 1'b0, "R2 no request before init", int'(ref_req), 0);

        // R8: grant with no request is ignored
        ref_gnt = 1'b1; bank_open = '1;
        step();
        ref_gnt = 1'b0; bank_open = '0;
        chk_cmd(5'b11110, 1'b0, "R8 grant without request ignored");

        // R1: first request timing
        init_done = 1'b1;
        repeat (INTERVAL - 1) step();
        chk(ref_req == 1'b0, "R1 request not yet due", int'(ref_req), 0);
        step();
        chk(ref_req == 1'b1, "R1 request at interval", int'(ref_req), 1);
        chk(m_pend == 1, "R1 model backlog", m_pend, 1);

        // Directed: all closed, each single bank, all open
        do_refresh('0);
        chk(ref_req == (m_pend > 0), "R9 backlog consumed", int'(ref_req), int'(m_pend > 0));
        for (int b = 0; b < NB; b++) begin
            wait_req();
            do_refresh(NB'(1) << b);
        end
        wait_req();
        do_refresh('1);

        // Random bank patterns and grant delays
        for (int r = 0; r < 12; r++) begin
            wait_req();
            repeat ($urandom_range(0, 5)) step();
            do_refresh(NB'($urandom));
            chk(ref_req == (m_pend > 0), "R9 request matches backlog",
                int'(ref_req), int'(m_pend > 0));
        end

        // R3/R4: fill past the limit, then drain
        repeat (10 * INTERVAL + 2) step();
        chk(ref_urgent == 1'b1, "R4 urgent when backlog full", int'(ref_urgent), 1);
        chk(ref_req == 1'b1, "R3 request when full", int'(ref_req), 1);
        pend0 = m_pend;
        adds0 = m_adds;
        chk(pend0 == 8, "R3 model saturated", pend0, 8);
        drained = 0;
        do_refresh(NB'($urandom));
        drained++;
        chk(ref_urgent == (m_pend == 8), "R4 urgent drops after refresh",
            int'(ref_urgent), int'(m_pend == 8));
        while (ref_req) begin
            do_refresh(NB'($urandom));
            drained++;
        end
        chk(drained == pend0 + (m_adds - adds0), "R3 drained count saturated at 8",
            drained, pend0 + (m_adds - adds0));
        chk(ref_urgent == 1'b0 && ref_req == 1'b0, "R9 drained idle",
            int'({ref_urgent, ref_req}), 0);

        finish_up();
    end

endmodule